// File: doc/BRIEF.md
# Strobe/Busy to Wishbone Bridge

This bridge sits between a compact processor core's memory port and a Wishbone classic bus. The core flags a store with a non-zero byte mask, or a load with a single-cycle read strobe. It shows the address, the store data and the mask for that one cycle only. The bridge captures those values in the request cycle and runs exactly one Wishbone single transfer from the captured copy. It then tells the core that the access is complete by letting the matching busy flag fall.

Only one access is in flight at a time. The bridge ignores any request that arrives while a transfer is running. Load data is registered from the bus on the acknowledge cycle and stays on the core's read-data port until the next load completes. The bus address is a word address: the byte address with its two lowest bits dropped. Loads enable all four byte lanes.

Top module: `sbwb_bridge`

## Requirements
- R1: While synchronous active-high reset is asserted, and on the first cycle after it is released, wb_cyc_o, wb_stb_o, cpu_rbusy and cpu_wbusy are all low.
- R2: A non-zero cpu_wmask seen while the bridge is idle starts a write. cpu_wbusy is high from the next cycle, and cpu_rbusy stays low for the whole write.
- R3: A cpu_rstrb pulse with cpu_wmask zero, seen while the bridge is idle, starts a read. cpu_rbusy is high from the next cycle, and cpu_wbusy stays low for the whole read.
- R4: wb_adr_o, wb_dat_o, wb_sel_o and wb_we_o come from values captured in the request cycle. They stay constant for the whole transfer even when the core's inputs change after the request cycle.
- R5: wb_adr_o equals cpu_addr[31:2] of the request. A write drives wb_we_o high, wb_sel_o equal to the request mask (bit n enables byte n, bits 8n+7..8n) and wb_dat_o equal to the request data. A read drives wb_we_o low and wb_sel_o to 4'b1111.
- R6: wb_cyc_o and wb_stb_o are equal and are high exactly while a busy flag is high. Both fall in the cycle after wb_ack_i is sampled high, so a slave that acks N cycles after it first sees the strobe gives N+2 busy cycles.
- R7: cpu_rdata takes wb_dat_i as sampled on the acknowledge edge of a read. It is valid when cpu_rbusy falls and stays unchanged through later writes and idle cycles.
- R8: A request presented while a transfer is in progress is ignored and causes no further bus transfer.
- R9: When a non-zero mask and cpu_rstrb arrive in the same idle cycle, only the write is performed.
- R10: While idle, with cpu_wmask zero and cpu_rstrb low, no bus transfer starts, whatever values cpu_addr and cpu_wdata carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | Byte address, valid in the request cycle only |
| cpu_wdata | input | 32 | Store data, valid in the request cycle only |
| cpu_wmask | input | 4 | Store byte enables; non-zero marks a write request |
| cpu_rstrb | input | 1 | One-cycle load request pulse |
| cpu_rdata | output | 32 | Load data, valid once cpu_rbusy is low |
| cpu_rbusy | output | 1 | Load in progress |
| cpu_wbusy | output | 1 | Store in progress |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | 30 | Wishbone word address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_sel_o | output | 4 | Wishbone byte lane selects |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
The assertions check, on every cycle, the invariants that span ports: cyc and stb agree with the busy flags, the two busy flags never rise together, and the bus fields hold steady during a transfer. They also check that a request seen while idle raises the right busy flag in the next cycle, that the bus drops one cycle after an acknowledge, and that load data equals the bus data from the acknowledge edge. Only the bench scenarios can show the parts that need a model of memory and of the slave. These are the exact busy length for each slave latency, the merged byte contents read back after every mask under several wait states, the capture of request values against core inputs that change afterwards, and the count of transfers when requests collide or arrive while the bridge is busy.

// File: rtl/sbwb_pkg.sv
package sbwb_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned SEL_W  = DATA_W / LANE_W;
    localparam int unsigned OFS_W  = $clog2(SEL_W);
    localparam int unsigned WADR_W = ADDR_W - OFS_W;

    localparam logic [SEL_W-1:0] SEL_ALL = {SEL_W{1'b1}};

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_BUS_WRITE = 2'd1,
        ST_BUS_READ  = 2'd2
    } bstate_t;

    typedef struct packed {
        logic [WADR_W-1:0] wadr;
        logic [DATA_W-1:0] data;
        logic [SEL_W-1:0]  sel;
        logic              we;
    } breq_t;

    function automatic logic [WADR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic is_store(input logic [SEL_W-1:0] m);
        return |m;
    endfunction
endpackage

// File: rtl/sbwb_req_capture.sv
module sbwb_req_capture
    import sbwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  wmask,
    output breq_t             req_q
);
    logic [WADR_W-1:0] wadr_q;
    logic              we_q;
    logic [DATA_W-1:0] data_w;
    logic [SEL_W-1:0]  sel_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            wadr_q <= '0;
            we_q   <= 1'b0;
        end else if (load) begin
            wadr_q <= word_of(addr);
            we_q   <= is_wr;
        end
    end

    // One register slice per byte lane: data and its select.
    for (genvar ln = 0; ln < SEL_W; ln++) begin : g_lane
        logic [LANE_W-1:0] d_q;
        logic              s_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                d_q <= '0;
                s_q <= 1'b0;
            end else if (load) begin
                d_q <= is_wr ? wdata[ln*LANE_W +: LANE_W] : '0;
                s_q <= is_wr ? wmask[ln] : 1'b1;
            end
        end
        assign data_w[ln*LANE_W +: LANE_W] = d_q;
        assign sel_w[ln]                   = s_q;
    end

    assign req_q = '{wadr: wadr_q, data: data_w, sel: sel_w, we: we_q};
endmodule

// File: rtl/sbwb_ctrl.sv
module sbwb_ctrl
    import sbwb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_req,
    input  logic    rd_req,
    input  logic    ack,
    output bstate_t state_q,
    output logic    launch,
    output logic    done
);
    bstate_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req)      state_d = ST_BUS_WRITE;
                else if (rd_req) state_d = ST_BUS_READ;
            end
            ST_BUS_WRITE,
            ST_BUS_READ: begin
                if (ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign launch = (state_q == ST_IDLE) && (wr_req || rd_req);
    assign done   = (state_q != ST_IDLE) && ack;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/sbwb_rdata.sv
module sbwb_rdata
    import sbwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_dat,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (capture) rdata_q <= bus_dat;
    end
endmodule

// File: rtl/sbwb_bridge.sv
module sbwb_bridge
    import sbwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [SEL_W-1:0]  cpu_wmask,
    input  logic              cpu_rstrb,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rbusy,
    output logic              cpu_wbusy,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [WADR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic [SEL_W-1:0]  wb_sel_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i
);
    bstate_t state;
    breq_t   req;
    logic    wr_req, rd_req, launch, done, rd_cap;

    // A store wins over a load presented in the same cycle.
    assign wr_req = is_store(cpu_wmask);
    assign rd_req = cpu_rstrb && !wr_req;

    sbwb_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .ack     (wb_ack_i),
        .state_q (state),
        .launch  (launch),
        .done    (done)
    );

    sbwb_req_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .load  (launch),
        .is_wr (wr_req),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .wmask (cpu_wmask),
        .req_q (req)
    );

    assign rd_cap = done && (state == ST_BUS_READ);

    sbwb_rdata u_rd (
        .clk     (clk),
        .rst     (rst),
        .capture (rd_cap),
        .bus_dat (wb_dat_i),
        .rdata_q (cpu_rdata)
    );

    assign cpu_wbusy = (state == ST_BUS_WRITE);
    assign cpu_rbusy = (state == ST_BUS_READ);
    assign wb_cyc_o  = (state != ST_IDLE);
    assign wb_stb_o  = (state != ST_IDLE);
    assign wb_we_o   = req.we;
    assign wb_adr_o  = req.wadr;
    assign wb_dat_o  = req.data;
    assign wb_sel_o  = req.sel;
endmodule

// File: rtl/sbwb_bridge_chk.sv
module sbwb_bridge_chk
    import sbwb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  cpu_wmask,
    input logic              cpu_rstrb,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_rbusy,
    input logic              cpu_wbusy,
    input logic              wb_cyc_o,
    input logic              wb_stb_o,
    input logic              wb_we_o,
    input logic [WADR_W-1:0] wb_adr_o,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic [SEL_W-1:0]  wb_sel_o,
    input logic [DATA_W-1:0] wb_dat_i,
    input logic              wb_ack_i
);
    logic idle;
    assign idle = !cpu_rbusy && !cpu_wbusy;

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wb_cyc_o && !wb_stb_o && !cpu_rbusy && !cpu_wbusy));

    // R2
    wr_start_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && (cpu_wmask != '0)) |=> (cpu_wbusy && !cpu_rbusy && wb_we_o));

    // R3
    rd_start_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && cpu_rstrb && (cpu_wmask == '0)) |=> (cpu_rbusy && !cpu_wbusy && !wb_we_o));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && $past(wb_cyc_o)) |->
            ($stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_sel_o) && $stable(wb_we_o)));

    // R5
    rd_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && !wb_we_o) |-> (wb_sel_o == SEL_ALL));

    // R6
    cyc_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o == wb_stb_o) && (wb_cyc_o == (cpu_rbusy || cpu_wbusy)));

    // R6
    ack_end_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

    // R7
    rdata_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rbusy) |-> (cpu_rdata == $past(wb_dat_i)));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rbusy && wb_ack_i) |=> $stable(cpu_rdata));

    // R8
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rbusy && cpu_wbusy));
endmodule

bind sbwb_bridge sbwb_bridge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_wmask (cpu_wmask),
    .cpu_rstrb (cpu_rstrb),
    .cpu_rdata (cpu_rdata),
    .cpu_rbusy (cpu_rbusy),
    .cpu_wbusy (cpu_wbusy),
    .wb_cyc_o  (wb_cyc_o),
    .wb_stb_o  (wb_stb_o),
    .wb_we_o   (wb_we_o),
    .wb_adr_o  (wb_adr_o),
    .wb_dat_o  (wb_dat_o),
    .wb_sel_o  (wb_sel_o),
    .wb_dat_i  (wb_dat_i),
    .wb_ack_i  (wb_ack_i)
);

// File: tb/sbwb_bridge_tb.sv
`timescale 1ns/1ps
module sbwb_bridge_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_wmask = '0;
    logic        cpu_rstrb = 1'b0;
    logic [31:0] cpu_rdata;
    logic        cpu_rbusy, cpu_wbusy;
    logic        wb_cyc_o, wb_stb_o, wb_we_o;
    logic [29:0] wb_adr_o;
    logic [31:0] wb_dat_o, wb_dat_i;
    logic [3:0]  wb_sel_o;
    logic        wb_ack_i;

    int n_chk = 0;
    int n_err = 0;
    int wait_cfg = 0;
    int txn = 0;
    logic [3:0]  cnt;
    logic [31:0] mem [16];
    logic [31:0] shadow [16];

    always #2.5 clk = ~clk;

    sbwb_bridge u_dut (.*);

    function automatic logic [31:0] init_word(input int i);
        return (32'(i) * 32'h0101_0101) ^ 32'h5A00_C300;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (m[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    // Wishbone slave model with a programmable acknowledge latency.
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_ack_i <= 1'b0;
            cnt      <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
        end else begin
            if (wb_cyc_o && wb_stb_o && !wb_ack_i) begin
                if (cnt == wait_cfg[3:0]) begin
                    wb_ack_i <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 4'd1;
                end
            end else begin
                wb_ack_i <= 1'b0;
            end
            if (wb_ack_i && wb_cyc_o && wb_we_o)
                mem[wb_adr_o[3:0]] <= merge(mem[wb_adr_o[3:0]], wb_dat_o, wb_sel_o);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wb_ack_i && wb_cyc_o) txn <= txn + 1;
    end

    assign wb_dat_i = wb_ack_i ? mem[wb_adr_o[3:0]] : 32'hDEAD_BEEF;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Presents one request, scrambles the core inputs afterwards and
    // follows the transfer cycle by cycle.
    task automatic run_txn(input logic [31:0] a, input logic [31:0] d, input logic [3:0] m,
                           input bit rd, input bit dual, input int w);
        int busy_n = 0;
        wait_cfg = w;
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wmask = rd ? 4'h0 : m;
        cpu_rstrb = rd || dual;
        @(negedge clk);
        cpu_addr  = ~a;
        cpu_wdata = ~d;
        cpu_wmask = 4'h0;
        cpu_rstrb = 1'b0;
        while ((cpu_rbusy || cpu_wbusy) && busy_n < 40) begin
            busy_n++;
            chk(wb_adr_o == a[31:2], "R4 R5 adr", {2'b0, wb_adr_o}, {2'b0, a[31:2]});
            chk(wb_we_o == !rd, "R5 we", {31'b0, wb_we_o}, {31'b0, !rd});
            chk(wb_sel_o == (rd ? 4'hF : m), "R5 sel", {28'b0, wb_sel_o},
                {28'b0, rd ? 4'hF : m});
            if (!rd) chk(wb_dat_o == d, "R4 dat", wb_dat_o, d);
            chk(wb_cyc_o && wb_stb_o, "R6 cyc", {31'b0, wb_cyc_o}, 32'd1);
            if (rd) chk(cpu_rbusy && !cpu_wbusy, "R3 rbusy", {30'b0, cpu_rbusy, cpu_wbusy}, 32'd2);
            else    chk(cpu_wbusy && !cpu_rbusy, "R2 R9 wbusy", {30'b0, cpu_rbusy, cpu_wbusy}, 32'd1);
            @(negedge clk);
        end
        chk(busy_n == w + 2, "R6 busy length", busy_n, w + 2);
        chk(!wb_cyc_o && !wb_stb_o, "R6 cyc drop", {31'b0, wb_cyc_o}, 32'd0);
        if (rd) chk(cpu_rdata == shadow[a[5:2]], "R7 rdata", cpu_rdata, shadow[a[5:2]]);
        else    shadow[a[5:2]] = merge(shadow[a[5:2]], d, m);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
        repeat (3) @(negedge clk);
        // R1: outputs idle while reset is held
        chk(!wb_cyc_o && !wb_stb_o && !cpu_rbusy && !cpu_wbusy, "R1 reset",
            {28'b0, wb_cyc_o, wb_stb_o, cpu_rbusy, cpu_wbusy}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!wb_cyc_o && !cpu_rbusy && !cpu_wbusy, "R1 after reset",
            {29'b0, wb_cyc_o, cpu_rbusy, cpu_wbusy}, 32'd0);

        // Sweep: every mask under four slave latencies, each write read back.
        for (int w = 0; w < 4; w++) begin
            for (int m = 1; m < 16; m++) begin
                int          idx = (w * 15 + m) % 16;
                logic [31:0] a   = 32'h0000_0100 + 32'(idx * 4) + 32'(m % 4);
                logic [31:0] d   = 32'h1357_9BDF * 32'(m + 1) + 32'(w * 32'h0011_0000);
                run_txn(a, d, 4'(m), 1'b0, 1'b0, w);
                run_txn(a, 32'h0, 4'h0, 1'b1, 1'b0, (w + m) % 4);
            end
        end

        // R7: read data held across a write and idle cycles
        begin
            logic [31:0] last;
            run_txn(32'h0000_0108, 32'h0, 4'h0, 1'b1, 1'b0, 1);
            last = cpu_rdata;
            run_txn(32'h0000_0110, 32'hCAFE_F00D, 4'hF, 1'b0, 1'b0, 2);
            repeat (3) @(negedge clk);
            chk(cpu_rdata == last, "R7 hold", cpu_rdata, last);
        end

        // R8: requests during a busy write are ignored
        begin
            int t0;
            t0 = txn;
            wait_cfg = 3;
            @(negedge clk);
            cpu_addr = 32'h0000_0104; cpu_wdata = 32'h0BAD_0001; cpu_wmask = 4'h3;
            @(negedge clk);
            cpu_addr = 32'h0000_0118; cpu_wdata = 32'hFFFF_FFFF; cpu_wmask = 4'hF; cpu_rstrb = 1'b1;
            @(negedge clk);
            cpu_wmask = 4'h0; cpu_rstrb = 1'b0;
            while (cpu_wbusy) @(negedge clk);
            repeat (4) @(negedge clk);
            chk(txn == t0 + 1, "R8 transfer count", txn, t0 + 1);
            chk(!cpu_rbusy && !wb_cyc_o, "R8 idle", {30'b0, cpu_rbusy, wb_cyc_o}, 32'd0);
            shadow[1] = merge(shadow[1], 32'h0BAD_0001, 4'h3);
            run_txn(32'h0000_0118, 32'h0, 4'h0, 1'b1, 1'b0, 0);
            run_txn(32'h0000_0104, 32'h0, 4'h0, 1'b1, 1'b0, 0);
        end

        // R9: simultaneous store and load strobe performs only the store
        begin
            int t0;
            t0 = txn;
            run_txn(32'h0000_011C, 32'h7777_AAAA, 4'h6, 1'b0, 1'b1, 1);
            repeat (2) @(negedge clk);
            chk(txn == t0 + 1, "R9 single transfer", txn, t0 + 1);
            run_txn(32'h0000_011C, 32'h0, 4'h0, 1'b1, 1'b0, 0);
        end

        // R10: no request, no transfer
        begin
            int t0;
            t0 = txn;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                cpu_addr  = 32'h8000_0000 + 32'(k * 4);
                cpu_wdata = 32'h1234_0000 + 32'(k);
                chk(!wb_cyc_o && !cpu_rbusy && !cpu_wbusy, "R10 stays idle",
                    {29'b0, wb_cyc_o, cpu_rbusy, cpu_wbusy}, 32'd0);
            end
            @(negedge clk);
            chk(txn == t0, "R10 transfer count", txn, t0);
        end

        summary();
        $finish;
    end
endmodule